// File: doc/BRIEF.md
# USB IN Transfer Packet Segmenter

This block turns one IN transfer request, a start address and a byte length, into a series of packets no larger than the endpoint's maximum packet size. For each packet it runs a fixed four-step issue sequence toward a DMA engine and the endpoint: it writes the packet size, then the buffer address, then starts the DMA, and last it releases the endpoint's NAK so the host can collect the packet. It then waits for the transmit acknowledge before it issues the next packet.

Before each packet the block holds off while the endpoint reports its transmit buffer as full. A per-packet cycle timer caps that wait, and the packet is issued anyway when the timer runs out. The block keeps a signed remaining count. After each packet the count drops by the whole maximum packet size, whatever the packet's real size was. On an acknowledge, a count of zero or more means another packet is due. A count of exactly zero gives a zero-length packet, which closes a transfer whose length is an exact multiple of the packet size. A negative count ends the transfer, and the block reports the originally requested length.

The request captures the speed and endpoint kind with the length. The maximum packet size is therefore fixed for the whole transfer.

Top module: `usb_in_segmenter`

## Requirements
- R1: After reset the block is idle: busy low, done low, and none of the four issue strobes active.
- R2: Each packet's size is the smaller of the remaining count and the maximum packet size. The maximum is 64 at full speed (highSpeed=0), 512 at high speed on a bulk endpoint (intrEp=0), and 1024 at high speed on an interrupt endpoint (intrEp=1).
- R3: A packet is issued as sizeWr, addrWr, dmaStart and nakClr, each high for exactly one cycle, on four consecutive cycles and in that order. pktSize and pktAddr hold steady across the four cycles.
- R4: The first packet's address is the requested start address. Each later packet's address is the previous address plus the previous packet's actual size.
- R5: After each packet the remaining count drops by the full maximum packet size. An acknowledge that finds the count at zero or above issues another packet, so a length that is a multiple of the maximum (including zero) ends with a zero-length packet.
- R6: An acknowledge that finds the remaining count negative ends the transfer. The cycle after that acknowledge, done is high for one cycle, doneLen equals the requested length, and busy is low.
- R7: While txBufFull is high the next packet waits. Without a full buffer, sizeWr rises two cycles after the accepted request or the acknowledge that triggered the packet. When the buffer stops being full, sizeWr rises on the cycle after the next clock edge.
- R8: If txBufFull stays high, the packet is issued anyway, with sizeWr rising TIMEOUT_CYC+1 cycles after the triggering request or acknowledge. The timer restarts for every packet.
- R9: busy is high from the cycle after an accepted request until completion. A request made while busy is ignored and does not change the packets or the reported length.
- R10: A transmit acknowledge while the block is idle has no effect: done stays low and no packet is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a transfer (taken only when idle) |
| reqAddr | input | ADDR_W | Start address of the transfer buffer |
| reqLen | input | LEN_W | Transfer length in bytes |
| highSpeed | input | 1 | 1 = high-speed link, 0 = full speed |
| intrEp | input | 1 | 1 = interrupt endpoint, 0 = bulk endpoint |
| txBufFull | input | 1 | Endpoint transmit buffer is full |
| txAck | input | 1 | Host acknowledged the last packet |
| sizeWr | output | 1 | Strobe: write packet size |
| addrWr | output | 1 | Strobe: write packet buffer address |
| dmaStart | output | 1 | Strobe: start the DMA |
| nakClr | output | 1 | Strobe: release endpoint NAK |
| pktSize | output | LEN_W | Size of the current packet |
| pktAddr | output | ADDR_W | Buffer address of the current packet |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| doneLen | output | LEN_W | Requested length of the finished transfer |

## Verification
The checker watches the issue sequence on every cycle. It confirms that the four strobes follow one another in order and never overlap with each other or with done, and that the size and address stay steady across the sequence. It also confirms that nothing is issued while idle, that done is a single-cycle pulse with busy low, and that a packet size never exceeds the largest maximum. The scenarios alone show the actual size arithmetic: the remaining count dropping by the full maximum, the trailing zero-length packet on exact multiples, the address stepping, and the cycle counts of the buffer-full wait and its timeout.

// File: rtl/usb_seg_pkg.sv
package usb_seg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ROOM,
    ST_WR_SIZE,
    ST_WR_ADDR,
    ST_DMA_GO,
    ST_NAK_REL,
    ST_WAIT_ACK
  } segState_t;

  typedef struct packed {
    logic load;
    logic tmrClr;
    logic tmrInc;
    logic advance;
  } segCtl_t;

endpackage

// File: rtl/usb_seg_datapath.sv
module usb_seg_datapath
  import usb_seg_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int FS_MAX      = 64,
  parameter int HS_BULK_MAX = 512,
  parameter int HS_INTR_MAX = 1024,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  segCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              highSpeed,
  input  logic              intrEp,
  output logic [LEN_W-1:0]  pktSize,
  output logic [ADDR_W-1:0] pktAddr,
  output logic [LEN_W-1:0]  origLen,
  output logic              remNeg,
  output logic              tmrExpired
);

  localparam int REM_W = LEN_W + 1;
  localparam int TMR_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic signed [REM_W-1:0] FS_V   = REM_W'(FS_MAX);
  localparam logic signed [REM_W-1:0] HSB_V  = REM_W'(HS_BULK_MAX);
  localparam logic signed [REM_W-1:0] HSI_V  = REM_W'(HS_INTR_MAX);
  localparam logic [TMR_W-1:0]        TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  logic signed [REM_W-1:0] remCnt;
  logic signed [REM_W-1:0] maxPkt;
  logic signed [REM_W-1:0] maxSel;
  logic [ADDR_W-1:0]       curAddr;
  logic [TMR_W-1:0]        tmrCnt;

  always_comb begin
    if (!highSpeed)  maxSel = FS_V;
    else if (intrEp) maxSel = HSI_V;
    else             maxSel = HSB_V;
  end

  always_comb begin
    if (remCnt > maxPkt) pktSize = maxPkt[LEN_W-1:0];
    else                 pktSize = remCnt[LEN_W-1:0];
  end

  assign pktAddr    = curAddr;
  assign remNeg     = remCnt[REM_W-1];
  assign tmrExpired = (tmrCnt == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remCnt  <= '0;
      maxPkt  <= FS_V;
      curAddr <= '0;
      origLen <= '0;
    end else if (ctl.load) begin
      remCnt  <= $signed({1'b0, reqLen});
      maxPkt  <= maxSel;
      curAddr <= reqAddr;
      origLen <= reqLen;
    end else if (ctl.advance) begin
      remCnt  <= remCnt - maxPkt;
      curAddr <= curAddr + ADDR_W'(pktSize);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           tmrCnt <= '0;
    else if (ctl.tmrClr) tmrCnt <= '0;
    else if (ctl.tmrInc) tmrCnt <= tmrCnt + 1'b1;
  end

endmodule

// File: rtl/usb_seg_ctrl.sv
module usb_seg_ctrl
  import usb_seg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    txBufFull,
  input  logic    txAck,
  input  logic    remNeg,
  input  logic    tmrExpired,
  output segCtl_t ctl,
  output logic    sizeWr,
  output logic    addrWr,
  output logic    dmaStart,
  output logic    nakClr,
  output logic    busy,
  output logic    done
);

  segState_t state, stateNext;
  logic      doneNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.load   = 1'b1;
        ctl.tmrClr = 1'b1;
        stateNext  = ST_WAIT_ROOM;
      end
      ST_WAIT_ROOM: begin
        if (!txBufFull || tmrExpired) stateNext = ST_WR_SIZE;
        else                          ctl.tmrInc = 1'b1;
      end
      ST_WR_SIZE: stateNext = ST_WR_ADDR;
      ST_WR_ADDR: stateNext = ST_DMA_GO;
      ST_DMA_GO:  stateNext = ST_NAK_REL;
      ST_NAK_REL: begin
        ctl.advance = 1'b1;
        stateNext   = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: if (txAck) begin
        if (remNeg) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end else begin
          ctl.tmrClr = 1'b1;
          stateNext  = ST_WAIT_ROOM;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign sizeWr   = (state == ST_WR_SIZE);
  assign addrWr   = (state == ST_WR_ADDR);
  assign dmaStart = (state == ST_DMA_GO);
  assign nakClr   = (state == ST_NAK_REL);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/usb_in_segmenter.sv
module usb_in_segmenter
  import usb_seg_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int FS_MAX      = 64,
  parameter int HS_BULK_MAX = 512,
  parameter int HS_INTR_MAX = 1024,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              highSpeed,
  input  logic              intrEp,
  input  logic              txBufFull,
  input  logic              txAck,
  output logic              sizeWr,
  output logic              addrWr,
  output logic              dmaStart,
  output logic              nakClr,
  output logic [LEN_W-1:0]  pktSize,
  output logic [ADDR_W-1:0] pktAddr,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  doneLen
);

  segCtl_t ctl;
  logic    remNeg;
  logic    tmrExpired;

  usb_seg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .txBufFull  (txBufFull),
    .txAck      (txAck),
    .remNeg     (remNeg),
    .tmrExpired (tmrExpired),
    .ctl        (ctl),
    .sizeWr     (sizeWr),
    .addrWr     (addrWr),
    .dmaStart   (dmaStart),
    .nakClr     (nakClr),
    .busy       (busy),
    .done       (done)
  );

  usb_seg_datapath #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .FS_MAX      (FS_MAX),
    .HS_BULK_MAX (HS_BULK_MAX),
    .HS_INTR_MAX (HS_INTR_MAX),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .highSpeed  (highSpeed),
    .intrEp     (intrEp),
    .pktSize    (pktSize),
    .pktAddr    (pktAddr),
    .origLen    (doneLen),
    .remNeg     (remNeg),
    .tmrExpired (tmrExpired)
  );

endmodule

// File: rtl/usb_seg_checker.sv
module usb_seg_checker #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int HS_INTR_MAX = 1024
) (
  input logic              clk,
  input logic              rstN,
  input logic              sizeWr,
  input logic              addrWr,
  input logic              dmaStart,
  input logic              nakClr,
  input logic [LEN_W-1:0]  pktSize,
  input logic [ADDR_W-1:0] pktAddr,
  input logic              busy,
  input logic              done
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !busy && !done && !sizeWr);

  // R3
  size_then_addr_chk: assert property (@(posedge clk) disable iff (!rstN) sizeWr |=> addrWr);

  // R3
  addr_then_dma_chk: assert property (@(posedge clk) disable iff (!rstN) addrWr |=> dmaStart);

  // R3
  dma_then_nak_chk: assert property (@(posedge clk) disable iff (!rstN) dmaStart |=> nakClr);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sizeWr, addrWr, dmaStart, nakClr, done}));

  // R3
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrWr || dmaStart || nakClr) |-> $stable(pktAddr) && $stable(pktSize));

  // R2
  size_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    sizeWr |-> pktSize <= LEN_W'(HS_INTR_MAX));

  // R5
  stay_busy_chk: assert property (@(posedge clk) disable iff (!rstN) nakClr |=> busy);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R9
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(sizeWr || addrWr || dmaStart || nakClr));

endmodule

bind usb_in_segmenter usb_seg_checker #(
  .ADDR_W      (ADDR_W),
  .LEN_W       (LEN_W),
  .HS_INTR_MAX (HS_INTR_MAX)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sizeWr   (sizeWr),
  .addrWr   (addrWr),
  .dmaStart (dmaStart),
  .nakClr   (nakClr),
  .pktSize  (pktSize),
  .pktAddr  (pktAddr),
  .busy     (busy),
  .done     (done)
);

// File: tb/usb_in_segmenter_bench.sv
module usb_in_segmenter_bench;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int TMO    = 12;
  localparam int NVEC   = 9;

  // vector: {highSpeed, intrEp, addr[31:0], len[15:0], expected packets[7:0]}
  localparam logic [57:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 32'h0000_1000, 16'd0,    8'd1},
    {1'b0, 1'b0, 32'h0000_2000, 16'd64,   8'd2},
    {1'b0, 1'b0, 32'h0000_3004, 16'd100,  8'd2},
    {1'b0, 1'b1, 32'h0000_4000, 16'd1,    8'd1},
    {1'b1, 1'b0, 32'h0001_0000, 16'd1024, 8'd3},
    {1'b1, 1'b0, 32'h0002_0010, 16'd700,  8'd2},
    {1'b1, 1'b1, 32'h0003_0000, 16'd1024, 8'd2},
    {1'b1, 1'b1, 32'h0004_0000, 16'd1500, 8'd2},
    {1'b0, 1'b1, 32'h0005_0000, 16'd200,  8'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic highSpeed = 1'b0;
  logic intrEp = 1'b0;
  logic txBufFull = 1'b0;
  logic txAck = 1'b0;
  logic sizeWr, addrWr, dmaStart, nakClr, busy, done;
  logic [LEN_W-1:0] pktSize, doneLen;
  logic [ADDR_W-1:0] pktAddr;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  usb_in_segmenter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TIMEOUT_CYC(TMO)) u_usb_in_segmenter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqLen(reqLen),
    .highSpeed(highSpeed), .intrEp(intrEp), .txBufFull(txBufFull), .txAck(txAck),
    .sizeWr(sizeWr), .addrWr(addrWr), .dmaStart(dmaStart), .nakClr(nakClr),
    .pktSize(pktSize), .pktAddr(pktAddr), .busy(busy), .done(done), .doneLen(doneLen)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitSize(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!sizeWr && lat < 400);
  endtask

  function automatic int maxFor(input bit hs, input bit ie);
    if (!hs) return 64;
    return ie ? 1024 : 512;
  endfunction

  // Runs one transfer with txBufFull low; expected values come from the requirements.
  task automatic runXfer(input bit hs, input bit ie, input logic [31:0] a0,
                         input int len, input int expPkts, input bit pokeReq);
    int rem = len;
    int a = a0;
    int mx = maxFor(hs, ie);
    int npk = 0;
    int lat;
    int sz;
    @(negedge clk);
    highSpeed = hs; intrEp = ie; reqAddr = a0; reqLen = LEN_W'(len); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R9 busy after request", busy, 1);
    highSpeed = ~hs; intrEp = ~ie;
    waitSize(lat);
    lat++;
    forever begin
      chk(lat == 2, "R7 issue latency", lat, 2);
      sz = (rem > mx) ? mx : rem;
      chk(pktSize == LEN_W'(sz), "R2 packet size", pktSize, sz);
      chk(pktAddr == ADDR_W'(a), "R4 packet address", pktAddr, a);
      npk++;
      @(negedge clk);
      chk(addrWr && !sizeWr, "R3 addr step", addrWr, 1);
      if (pokeReq) begin
        reqValid = 1'b1; reqLen = 16'd7; reqAddr = 32'hDEAD_0000;
      end
      @(negedge clk);
      reqValid = 1'b0;
      chk(dmaStart, "R3 dma step", dmaStart, 1);
      @(negedge clk);
      chk(nakClr, "R3 nak step", nakClr, 1);
      rem -= mx;
      a += sz;
      @(negedge clk);
      chk(busy && !done && !sizeWr, "R5 wait for ack", busy, 1);
      txAck = 1'b1;
      @(negedge clk);
      txAck = 1'b0;
      if (rem < 0) break;
      waitSize(lat);
      lat++;
    end
    chk(done == 1'b1, "R6 done pulse", done, 1);
    chk(doneLen == LEN_W'(len), "R6 reported length", doneLen, len);
    chk(busy == 1'b0, "R6 idle after done", busy, 0);
    chk(npk == expPkts, "R5 packet count", npk, expPkts);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sizeWr && !addrWr && !dmaStart && !nakClr, "R1 reset idle", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset release", busy, 0);

    for (int i = 0; i < NVEC; i++) begin
      runXfer(VEC[i][57], VEC[i][56], VEC[i][55:24], int'(VEC[i][23:8]), int'(VEC[i][7:0]), 1'b0);
    end

    // R9: a request while busy is ignored
    runXfer(1'b0, 1'b0, 32'h0000_8000, 130, 3, 1'b1);

    // R10: acknowledge while idle
    txAck = 1'b1;
    @(negedge clk);
    txAck = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!done && !busy && !sizeWr, "R10 idle ack ignored", done, 0);
    end

    // R7: buffer full for 5 cycles, then clears
    txBufFull = 1'b1;
    highSpeed = 1'b0; intrEp = 1'b0; reqAddr = 32'h100; reqLen = 16'd10; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!sizeWr, "R7 hold while full", sizeWr, 0);
    end
    txBufFull = 1'b0;
    @(negedge clk);
    chk(sizeWr == 1'b1, "R7 issue after full clears", sizeWr, 1);
    chk(pktSize == 16'd10, "R2 short packet", pktSize, 10);
    repeat (3) @(negedge clk);
    @(negedge clk);
    txAck = 1'b1;
    @(negedge clk);
    txAck = 1'b0;
    chk(done == 1'b1, "R6 done after held packet", done, 1);

    // R8: buffer stuck full, timeout on both packets
    txBufFull = 1'b1;
    reqAddr = 32'h200; reqLen = 16'd64; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitSize(lat);
    lat++;
    chk(lat == TMO + 1, "R8 first timeout", lat, TMO + 1);
    repeat (3) @(negedge clk);
    @(negedge clk);
    txAck = 1'b1;
    @(negedge clk);
    txAck = 0;
    waitSize(lat);
    lat++;
    chk(lat == TMO + 1, "R8 timer restarts", lat, TMO + 1);
    chk(pktSize == 16'd0, "R5 zero-length tail", pktSize, 0);
    chk(pktAddr == 32'h240, "R4 tail address", pktAddr, 32'h240);
    repeat (3) @(negedge clk);
    @(negedge clk);
    txAck = 1'b1;
    @(negedge clk);
    txAck = 1'b0;
    txBufFull = 1'b0;
    chk(done && doneLen == 16'd64, "R6 done after timeouts", doneLen, 64);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule